// File: doc/BRIEF.md
# Per-pixel display colour selector

This block sits in the display-refresh path. For every pixel it receives two stored 24-bit image words, an 8-bit overlay index, a 10-bit window identifier and one fast-clear valid bit, and it returns one final 24-bit colour. The window identifier addresses a table of window attributes. That table chooses, for each pixel separately, which of the two image buffers is visible, whether the image word is true colour or an index into a shared 256-entry colour map, whether a zero overlay index counts as see-through, and which fast-clear background set applies.

The layers are resolved in a fixed priority order. A solid overlay wins over everything else and is shown through the colour map. A pixel whose fast-clear bit is clear comes next and takes the background colour of its set. The image comes last. Three sync/blank flags travel beside the pixel with the same delay. The window table, the colour map and the three background colours are loaded through a single write port.

Top module: `pix_out_sel`

## Requirements
- R1: While reset is asserted, out_rgb, out_hsync, out_vsync and out_blank are all 0.
- R2: The colour for a pixel presented at the inputs before clock edge k appears at the outputs after edge k+1. The hsync, vsync and blank flags are delayed by exactly the same two edges.
- R3: A window-table entry is 5 bits: bit 0 selects the visible buffer (0 = A, 1 = B), bit 1 selects the colour model (0 = true colour, 1 = indexed), bit 2 marks a zero overlay as see-through, and bits 4:3 give the fast-clear set (0, 1 or 2; 3 = no set).
- R4: In a true-colour window with no overlay and no background, out_rgb equals the selected 24-bit buffer word unchanged (red 23:16, green 15:8, blue 7:0).
- R5: In an indexed window with no overlay and no background, out_rgb is the colour-map entry addressed by bits 7:0 of the selected buffer word.
- R6: The overlay is solid when its index is non-zero or when entry bit 2 is 0. A solid overlay shows the colour-map entry at the overlay index, whatever the fast-clear bit and the image hold.
- R7: A zero overlay index in a window whose entry bit 2 is 1 is see-through, and the layers below it are shown.
- R8: When the fast-clear bit is 0, the set is 0 to 2 and the overlay is not solid, out_rgb is that set's background colour, even in place of an indexed or true-colour image.
- R9: When the set field is 3, the fast-clear bit has no effect and the image is shown.
- R10: A write uses cfg_addr[11:10] as the space: 0 writes the window table at cfg_addr[9:0] with cfg_wdata[4:0]; 1 writes the colour map at cfg_addr[7:0] with cfg_wdata; 2 writes the background colour of set cfg_addr[1:0]. Writes to space 3, and background writes to set 3, change nothing.
- R11: The three background colours reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_a | input | 24 | Image buffer A word |
| pix_b | input | 24 | Image buffer B word |
| pix_ovl | input | 8 | Overlay colour index |
| pix_wid | input | 10 | Window identifier |
| pix_fc | input | 1 | Fast-clear valid bit |
| in_hsync | input | 1 | Horizontal sync flag in |
| in_vsync | input | 1 | Vertical sync flag in |
| in_blank | input | 1 | Blank flag in |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | 12 | Table write address (space and index) |
| cfg_wdata | input | 24 | Table write data |
| out_rgb | output | 24 | Final pixel colour |
| out_hsync | output | 1 | Delayed horizontal sync |
| out_vsync | output | 1 | Delayed vertical sync |
| out_blank | output | 1 | Delayed blank |

## Verification
The layer-priority assertions assume that no table entry changes while a pixel that reads it is still inside the two-stage pipeline. They also assume that every window identifier and colour-map index a pixel uses has been loaded, because those memories have no reset value. The stimulus loads all tables while no checked pixel is in flight and leaves three idle cycles after each group of writes. It draws random window identifiers only from loaded entries, and it keeps random image low bytes and overlay indices inside the loaded part of the colour map.

// File: rtl/pos_pkg.sv
package pos_pkg;
    localparam int CH_W        = 8;
    localparam int RGB_W       = 3 * CH_W;
    localparam int NUM_FC_SETS = 3;
    localparam int FC_SEL_W    = 2;

    // window attribute word; field positions are decoded by software writes
    typedef struct packed {
        logic [FC_SEL_W-1:0] fc_set;       // bits 4:3
        logic                ovl_clear_ok; // bit 2
        logic                indexed;      // bit 1
        logic                buf_b;        // bit 0
    } win_attr_t;

    localparam int WIN_ATTR_W = $bits(win_attr_t);

    typedef enum logic [1:0] {
        SPACE_WIN  = 2'd0,
        SPACE_CMAP = 2'd1,
        SPACE_BG   = 2'd2,
        SPACE_NONE = 2'd3
    } cfg_space_e;

    typedef enum logic [1:0] {
        SRC_OVL,
        SRC_BG,
        SRC_MAP,
        SRC_TRUE
    } pix_src_e;
endpackage

// File: rtl/pos_win_table.sv
module pos_win_table
    import pos_pkg::*;
#(
    parameter int WID_W = 10
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [WID_W-1:0] wr_idx,
    input  win_attr_t        wr_attr,
    input  logic [WID_W-1:0] rd_idx,
    output win_attr_t        rd_attr
);
    localparam int DEPTH = 1 << WID_W;

    win_attr_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_attr;
        rd_attr <= mem[rd_idx];
    end
endmodule

// File: rtl/pos_cmap.sv
module pos_cmap #(
    parameter int IDX_W  = 8,
    parameter int RGB_W  = 24,
    parameter int NUM_RD = 2
) (
    input  logic                          clk,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [RGB_W-1:0]              wr_rgb,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][RGB_W-1:0]  rd_rgb
);
    localparam int DEPTH = 1 << IDX_W;

    logic [RGB_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_rgb;
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_rgb[p] = mem[rd_idx[p]];
    end
endmodule

// File: rtl/pos_bg_bank.sv
module pos_bg_bank #(
    parameter int NUM_SETS = 3,
    parameter int SEL_W    = 2,
    parameter int RGB_W    = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [RGB_W-1:0] rd_rgb
);
    logic [NUM_SETS-1:0][RGB_W-1:0] bg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bg_q <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                if (wr_sel == SEL_W'(s)) bg_q[s] <= wr_rgb;
            end
        end
    end

    always_comb begin
        rd_rgb = '0;
        for (int s = 0; s < NUM_SETS; s++) begin
            if (rd_sel == SEL_W'(s)) rd_rgb = bg_q[s];
        end
    end
endmodule

// File: rtl/pos_mix.sv
module pos_mix
    import pos_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int NUM_SETS = 3,
    parameter int SEL_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             is_indexed,
    input  logic             ovl_clear_ok,
    input  logic [SEL_W-1:0] fc_set,
    input  logic [IDX_W-1:0] ovl_val,
    input  logic             fc_bit,
    input  logic [RGB_W-1:0] img_rgb,
    input  logic [RGB_W-1:0] ovl_rgb,
    input  logic [RGB_W-1:0] map_rgb,
    input  logic [RGB_W-1:0] bg_rgb,
    input  logic [2:0]       sync_in,
    output logic [RGB_W-1:0] rgb_out,
    output logic [2:0]       sync_out
);
    localparam logic [SEL_W-1:0] SET_LIMIT = SEL_W'(NUM_SETS);

    pix_src_e         src;
    logic [RGB_W-1:0] nxt_rgb;

    always_comb begin
        if (ovl_val != '0 || !ovl_clear_ok)       src = SRC_OVL;
        else if (!fc_bit && fc_set < SET_LIMIT)   src = SRC_BG;
        else if (is_indexed)                      src = SRC_MAP;
        else                                      src = SRC_TRUE;
    end

    always_comb begin
        unique case (src)
            SRC_OVL:  nxt_rgb = ovl_rgb;
            SRC_BG:   nxt_rgb = bg_rgb;
            SRC_MAP:  nxt_rgb = map_rgb;
            SRC_TRUE: nxt_rgb = img_rgb;
            default:  nxt_rgb = img_rgb;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rgb_out  <= '0;
            sync_out <= '0;
        end else begin
            rgb_out  <= nxt_rgb;
            sync_out <= sync_in;
        end
    end
endmodule

// File: rtl/pix_out_sel.sv
module pix_out_sel
    import pos_pkg::*;
#(
    parameter int WID_W = 10,
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [RGB_W-1:0]     pix_a,
    input  logic [RGB_W-1:0]     pix_b,
    input  logic [IDX_W-1:0]     pix_ovl,
    input  logic [WID_W-1:0]     pix_wid,
    input  logic                 pix_fc,
    input  logic                 in_hsync,
    input  logic                 in_vsync,
    input  logic                 in_blank,
    input  logic                 cfg_we,
    input  logic [WID_W+1:0]     cfg_addr,
    input  logic [RGB_W-1:0]     cfg_wdata,
    output logic [RGB_W-1:0]     out_rgb,
    output logic                 out_hsync,
    output logic                 out_vsync,
    output logic                 out_blank
);
    localparam int ADDR_W = WID_W + 2;

    // write decode
    cfg_space_e space;
    logic       win_we, map_we, bg_we;

    assign space  = cfg_space_e'(cfg_addr[ADDR_W-1 -: 2]);
    assign win_we = cfg_we && (space == SPACE_WIN);
    assign map_we = cfg_we && (space == SPACE_CMAP);
    assign bg_we  = cfg_we && (space == SPACE_BG);

    // stage 1: pixel data registered beside the window-table read
    logic [RGB_W-1:0] img_a_s1, img_b_s1;
    logic [IDX_W-1:0] ovl_s1;
    logic             fc_s1;
    logic [2:0]       sync_s1;
    win_attr_t        win_s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            img_a_s1 <= '0;
            img_b_s1 <= '0;
            ovl_s1   <= '0;
            fc_s1    <= 1'b0;
            sync_s1  <= '0;
        end else begin
            img_a_s1 <= pix_a;
            img_b_s1 <= pix_b;
            ovl_s1   <= pix_ovl;
            fc_s1    <= pix_fc;
            sync_s1  <= {in_hsync, in_vsync, in_blank};
        end
    end

    pos_win_table #(.WID_W(WID_W)) u_win (
        .clk     (clk),
        .wr_en   (win_we),
        .wr_idx  (cfg_addr[WID_W-1:0]),
        .wr_attr (win_attr_t'(cfg_wdata[WIN_ATTR_W-1:0])),
        .rd_idx  (pix_wid),
        .rd_attr (win_s1)
    );

    // stage 2: colour lookups and layer selection
    logic [RGB_W-1:0]            img_sel;
    logic [1:0][IDX_W-1:0]       map_idx;
    logic [1:0][RGB_W-1:0]       map_out;
    logic [RGB_W-1:0]            bg_rgb;
    logic [2:0]                  sync_o;

    assign img_sel    = win_s1.buf_b ? img_b_s1 : img_a_s1;
    assign map_idx[0] = img_sel[IDX_W-1:0];
    assign map_idx[1] = ovl_s1;

    pos_cmap #(.IDX_W(IDX_W), .RGB_W(RGB_W), .NUM_RD(2)) u_cmap (
        .clk    (clk),
        .wr_en  (map_we),
        .wr_idx (cfg_addr[IDX_W-1:0]),
        .wr_rgb (cfg_wdata),
        .rd_idx (map_idx),
        .rd_rgb (map_out)
    );

    pos_bg_bank #(.NUM_SETS(NUM_FC_SETS), .SEL_W(FC_SEL_W), .RGB_W(RGB_W)) u_bg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bg_we),
        .wr_sel (cfg_addr[FC_SEL_W-1:0]),
        .wr_rgb (cfg_wdata),
        .rd_sel (win_s1.fc_set),
        .rd_rgb (bg_rgb)
    );

    pos_mix #(.IDX_W(IDX_W), .NUM_SETS(NUM_FC_SETS), .SEL_W(FC_SEL_W)) u_mix (
        .clk          (clk),
        .rst_n        (rst_n),
        .is_indexed   (win_s1.indexed),
        .ovl_clear_ok (win_s1.ovl_clear_ok),
        .fc_set       (win_s1.fc_set),
        .ovl_val      (ovl_s1),
        .fc_bit       (fc_s1),
        .img_rgb      (img_sel),
        .ovl_rgb      (map_out[1]),
        .map_rgb      (map_out[0]),
        .bg_rgb       (bg_rgb),
        .sync_in      (sync_s1),
        .rgb_out      (out_rgb),
        .sync_out     (sync_o)
    );

    assign {out_hsync, out_vsync, out_blank} = sync_o;
endmodule

// File: rtl/pos_chk.sv
module pos_chk
    import pos_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input win_attr_t        win,
    input logic [IDX_W-1:0] ovl,
    input logic             fc,
    input logic [RGB_W-1:0] img,
    input logic [RGB_W-1:0] ovl_rgb,
    input logic [RGB_W-1:0] map_rgb,
    input logic [RGB_W-1:0] bg_rgb,
    input logic [2:0]       flags_in,
    input logic [RGB_W-1:0] rgb_out,
    input logic [2:0]       flags_out
);
    logic [1:0] since_rst;
    logic       solid;
    logic       bg_on;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    assign solid = (ovl != '0) || !win.ovl_clear_ok;
    assign bg_on = !fc && (win.fc_set != 2'd3);

    AST_FLAG_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (flags_out == $past(flags_in, 2))); // R2

    AST_OVL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && solid) |=> (rgb_out == $past(ovl_rgb))); // R6

    AST_BG_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !solid && bg_on) |=> (rgb_out == $past(bg_rgb))); // R8

    AST_MAP_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !solid && !bg_on && win.indexed) |=> (rgb_out == $past(map_rgb))); // R5

    AST_TRUE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd1 && !solid && !bg_on && !win.indexed) |=> (rgb_out == $past(img))); // R4
endmodule

bind pix_out_sel pos_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .win       (win_s1),
    .ovl       (ovl_s1),
    .fc        (fc_s1),
    .img       (img_sel),
    .ovl_rgb   (map_out[1]),
    .map_rgb   (map_out[0]),
    .bg_rgb    (bg_rgb),
    .flags_in  ({in_hsync, in_vsync, in_blank}),
    .rgb_out   (out_rgb),
    .flags_out ({out_hsync, out_vsync, out_blank})
);

// File: tb/pix_out_sel_tb.sv
module pix_out_sel_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] pix_a, pix_b, cfg_wdata, out_rgb;
    logic [7:0]  pix_ovl;
    logic [9:0]  pix_wid;
    logic        pix_fc, in_hsync, in_vsync, in_blank, cfg_we;
    logic [11:0] cfg_addr;
    logic        out_hsync, out_vsync, out_blank;

    always #10 clk = ~clk; // 50 MHz

    pix_out_sel u_dut (
        .clk(clk), .rst_n(rst_n), .pix_a(pix_a), .pix_b(pix_b), .pix_ovl(pix_ovl),
        .pix_wid(pix_wid), .pix_fc(pix_fc), .in_hsync(in_hsync), .in_vsync(in_vsync),
        .in_blank(in_blank), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .out_rgb(out_rgb), .out_hsync(out_hsync), .out_vsync(out_vsync), .out_blank(out_blank)
    );

    int errors = 0;
    int checks = 0;
    int cyc    = 0;
    int npix   = 0;

    // reference tables kept by the bench
    logic [4:0]  win_m [1024];
    logic [23:0] cmap_m [256];
    logic [23:0] bg_m [3];

    // scoreboard
    logic [23:0] q_rgb [$];
    logic [2:0]  q_flg [$];
    int          q_due [$];
    string       q_tag [$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [23:0] expect_rgb(input logic [9:0] w, input logic [23:0] a,
                                               input logic [23:0] b, input logic [7:0] o,
                                               input logic f);
        logic [4:0]  at;
        logic [23:0] img;
        at  = win_m[w];
        img = at[0] ? b : a;
        if (o != 8'd0 || !at[2])        return cmap_m[o];
        if (!f && at[4:3] != 2'd3)      return bg_m[at[4:3]];
        if (at[1])                      return cmap_m[img[7:0]];
        return img;
    endfunction

    task automatic drive_pix(input logic [9:0] w, input logic [23:0] a, input logic [23:0] b,
                             input logic [7:0] o, input logic f, input string tag);
        logic [2:0] fl;
        fl = 3'(npix);
        npix++;
        pix_wid = w; pix_a = a; pix_b = b; pix_ovl = o; pix_fc = f;
        {in_hsync, in_vsync, in_blank} = fl;
        q_rgb.push_back(expect_rgb(w, a, b, o, f));
        q_flg.push_back(fl);
        q_due.push_back(cyc + 2);
        q_tag.push_back(tag);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (q_due.size() > 0 && q_due[0] == cyc) begin
            logic [23:0] er;
            logic [2:0]  ef;
            string       t;
            void'(q_due.pop_front());
            er = q_rgb.pop_front();
            ef = q_flg.pop_front();
            t  = q_tag.pop_front();
            checks++;
            if (out_rgb !== er || {out_hsync, out_vsync, out_blank} !== ef) begin
                errors++;
                $display("FAIL %s: rgb=%h flags=%b expected rgb=%h flags=%b",
                         t, out_rgb, {out_hsync, out_vsync, out_blank}, er, ef);
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sp, input logic [9:0] idx, input logic [23:0] d);
        cfg_we = 1'b1; cfg_addr = {sp, idx}; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (sp)
            2'd0: win_m[idx] = d[4:0];
            2'd1: cmap_m[idx[7:0]] = d;
            2'd2: if (idx[1:0] != 2'd3) bg_m[idx[1:0]] = d;
            default: ;
        endcase
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog R2: run hung, actual=timeout expected=done");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        pix_a = '0; pix_b = '0; pix_ovl = '0; pix_wid = '0; pix_fc = 1'b0;
        in_hsync = 1'b1; in_vsync = 1'b1; in_blank = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs held at zero under reset, despite flags driven high
        checks++;
        if (out_rgb !== 24'h0 || {out_hsync, out_vsync, out_blank} !== 3'b000) begin
            errors++;
            $display("FAIL R1: rgb=%h flags=%b expected rgb=000000 flags=000",
                     out_rgb, {out_hsync, out_vsync, out_blank});
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R3 entries: {set, ovl_clear_ok, indexed, buf_b}
        cfg_write(2'd0, 10'd1, 24'b11100); // A, true, see-through, no set
        cfg_write(2'd0, 10'd2, 24'b00101); // B, true, see-through, set 0
        cfg_write(2'd0, 10'd3, 24'b01110); // A, indexed, see-through, set 1
        cfg_write(2'd0, 10'd4, 24'b10011); // B, indexed, overlay always solid, set 2
        cfg_write(2'd0, 10'd5, 24'b10100); // A, true, see-through, set 2
        bg_m[0] = '0; bg_m[1] = '0; bg_m[2] = '0;
        drain();

        // R11: background 0 reads as zero after reset
        drive_pix(10'd2, 24'h123456, 24'h654321, 8'd0, 1'b0, "R11 background reset");
        drain();

        for (int i = 0; i < 16; i++)
            cfg_write(2'd1, 10'(i), {8'(i * 37 + 1), 8'(i * 11 + 3), 8'(255 - i)});
        cfg_write(2'd2, 10'd0, 24'hA0B0C0);
        cfg_write(2'd2, 10'd1, 24'h102030);
        cfg_write(2'd2, 10'd2, 24'hFEDCBA);
        drain();

        drive_pix(10'd1, 24'hABCDEF, 24'h111111, 8'd0, 1'b0, "R9 no-set ignores fast clear");
        drive_pix(10'd2, 24'h111111, 24'h89ABCD, 8'd0, 1'b1, "R4 true colour buffer B");
        drive_pix(10'd1, 24'h445566, 24'h778899, 8'd0, 1'b1, "R4 true colour buffer A");
        drive_pix(10'd2, 24'h111111, 24'h222222, 8'd0, 1'b0, "R8 background set 0");
        drive_pix(10'd3, 24'hFFFF07, 24'h000000, 8'd0, 1'b1, "R5 indexed from buffer A");
        drive_pix(10'd3, 24'hFFFF07, 24'h000000, 8'd0, 1'b0, "R8 background over indexed");
        drive_pix(10'd4, 24'h000000, 24'h00000C, 8'd0, 1'b1, "R7 zero overlay solid when not see-through");
        drive_pix(10'd1, 24'hABCDEF, 24'h000000, 8'd5, 1'b1, "R6 solid overlay over true colour");
        drive_pix(10'd3, 24'h000002, 24'h000000, 8'd9, 1'b0, "R6 solid overlay over background");
        drive_pix(10'd2, 24'h000000, 24'h5A5A5A, 8'd0, 1'b1, "R7 see-through zero overlay");
        drive_pix(10'd5, 24'h314159, 24'h000000, 8'd0, 1'b0, "R8 background set 2");
        drive_pix(10'd4, 24'h000000, 24'h000003, 8'd4, 1'b0, "R6 overlay index 4");
        drain();

        // R10: space 3 and set 3 writes are dropped
        cfg_write(2'd3, 10'd7, 24'hDEAD01);
        cfg_write(2'd3, 10'd3, 24'b00000);
        cfg_write(2'd2, 10'd3, 24'hDEAD02);
        drain();
        drive_pix(10'd3, 24'h000007, 24'h000000, 8'd0, 1'b1, "R10 space 3 ignored by colour map");
        drive_pix(10'd5, 24'h000000, 24'h000000, 8'd0, 1'b0, "R10 set 3 write ignored");
        drive_pix(10'd2, 24'h000000, 24'h000000, 8'd0, 1'b0, "R10 set 0 intact");
        drain();

        // R10: rewrite a live colour map entry and window entry
        cfg_write(2'd1, 10'd7, 24'h0F1E2D);
        cfg_write(2'd0, 10'd1, 24'b01110);
        drain();
        drive_pix(10'd3, 24'h000007, 24'h000000, 8'd0, 1'b1, "R10 colour map rewrite");
        drive_pix(10'd1, 24'h000007, 24'h000000, 8'd0, 1'b1, "R10 window rewrite");
        drain();

        // R2: back-to-back mixed pixels
        for (int i = 0; i < 60; i++) begin
            logic [9:0]  w;
            logic [23:0] a, b;
            logic [7:0]  o;
            w = 10'($urandom_range(1, 5));
            a = {16'($urandom), 8'($urandom_range(0, 15))};
            b = {16'($urandom), 8'($urandom_range(0, 15))};
            o = ($urandom_range(0, 1) == 0) ? 8'd0 : 8'($urandom_range(1, 15));
            drive_pix(w, a, b, o, 1'($urandom), "R2 streaming mix");
        end
        drain();

        if (q_due.size() != 0) begin
            errors++; checks++;
            $display("FAIL R2: pending=%0d expected pending=0", q_due.size());
        end
        finish_run();
    end
endmodule